// File: doc/BRIEF.md
# KISS Framed Byte Stream Decoder

This block turns a KISS-framed serial byte stream back into raw payload bytes. Bytes arrive one per clock, qualified by a valid strobe. The block finds the delimiters and strips them out. It also folds each two-byte escape sequence back into the single byte it stands for. The result is a strobed payload stream with a one-cycle frame-start pulse and a one-cycle frame-end pulse.

A frame is force-closed once its payload reaches a configurable limit. The default limit is 256 bytes. The block recovers from malformed input in two ways: an unknown byte after an escape is dropped, and a delimiter inside an escape ends the frame.

There is no back-pressure in either direction. Every qualified input byte is consumed in the cycle it is presented. Each output pulse must be taken in the cycle it appears. All outputs are registered, so they reflect the byte accepted at the previous clock edge.

Top module: `kiss_stream_decoder`

## Requirements
- R1: `rst` is synchronous and active-high. While it is held, all three output strobes are low. After it is released, the decoder is outside any frame, so a payload byte produces no output until a delimiter arrives.
- R2: When the decoder is outside a frame and accepts 0xC0, it pulses `out_sof` for one cycle. It then enters the frame body with its payload count cleared. No `out_valid` and no `out_eof` accompany that pulse.
- R3: In the frame body, any accepted byte other than 0xC0 and 0xDB appears unchanged on `out_byte`, with `out_valid` high for exactly one cycle.
- R4: In the frame body, an accepted 0xC0 pulses `out_eof` for one cycle and leaves the frame, with no `out_valid`.
- R5: In the frame body, an accepted 0xDB produces no output and arms the escape. The next accepted byte is then decoded: 0xDC yields payload byte 0xC0, and 0xDD yields payload byte 0xDB. The decoded byte is emitted with `out_valid`, and decoding returns to the body.
- R6: An armed escape followed by any byte other than 0xC0, 0xDC or 0xDD produces no output and returns to the body.
- R7: An armed escape followed by 0xC0 is an error. It pulses `out_eof` for one cycle without `out_valid` and leaves the frame.
- R8: The payload byte that brings the frame's count to MAX_LEN is emitted with `out_valid` and `out_eof` together, and the frame is left at that point. Non-delimiter bytes that follow are ignored. A following 0xC0 opens a new frame.
- R9: Cycles with `in_valid` low leave the decoding state and the payload count unchanged, and all three output strobes are low.
- R10: Outside a frame, accepted bytes other than 0xC0 are ignored and produce no output.
- R11: The payload count never exceeds MAX_LEN, and `out_sof` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_byte` in this cycle |
| in_byte | input | 8 | Framed input byte |
| out_valid | output | 1 | One-cycle strobe: `out_byte` carries a payload byte |
| out_byte | output | 8 | Decoded payload byte |
| out_sof | output | 1 | One-cycle frame-start pulse |
| out_eof | output | 1 | One-cycle frame-end pulse (delimiter, error or length limit) |

## Verification
The bench builds the decoder with its default limit of 256 payload bytes. This brings a full-length frame within reach in a few hundred cycles. The bench checks every byte of that frame, confirms that the end pulse coincides with the 256th byte, and confirms that bytes following the forced close are ignored. A short vector table covers escapes, invalid escapes, an error inside an escape, empty frames and idle gaps. Directed tests cover reset both at start-up and in the middle of a frame.

// File: rtl/kdec_pkg.sv
package kdec_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] DELIM    = 8'hC0;
  localparam logic [BYTE_W-1:0] ESC      = 8'hDB;
  localparam logic [BYTE_W-1:0] ESC_DLM  = 8'hDC;
  localparam logic [BYTE_W-1:0] ESC_ESC  = 8'hDD;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BODY = 2'd1,
    ST_ESC  = 2'd2
  } kdec_state_t;

  typedef struct packed {
    logic is_delim;
    logic is_esc;
    logic is_esc_dlm;
    logic is_esc_esc;
  } kdec_class_t;
endpackage

// File: rtl/kdec_classify.sv
module kdec_classify
  import kdec_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output kdec_class_t       cls_o
);
  always_comb begin
    cls_o.is_delim   = (byte_i == DELIM);
    cls_o.is_esc     = (byte_i == ESC);
    cls_o.is_esc_dlm = (byte_i == ESC_DLM);
    cls_o.is_esc_esc = (byte_i == ESC_ESC);
  end
endmodule

// File: rtl/kdec_ctrl.sv
module kdec_ctrl
  import kdec_pkg::*;
#(
  parameter int MAX_LEN = 256,
  localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  kdec_class_t       cls_i,
  output logic              emit_o,
  output logic [BYTE_W-1:0] emit_byte_o,
  output logic              sof_o,
  output logic              eof_o,
  output kdec_state_t       st_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_LEN);

  kdec_state_t      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    emit_o      = 1'b0;
    emit_byte_o = byte_i;
    sof_o       = 1'b0;
    eof_o       = 1'b0;
    if (valid_i) begin
      unique case (st_q)
        ST_IDLE: begin
          if (cls_i.is_delim) begin
            sof_o = 1'b1;
            st_d  = ST_BODY;
            cnt_d = '0;
          end
        end
        ST_BODY: begin
          if (cls_i.is_delim) begin
            eof_o = 1'b1;
            st_d  = ST_IDLE;
          end else if (cls_i.is_esc) begin
            st_d = ST_ESC;
          end else begin
            emit_o = 1'b1;
          end
        end
        ST_ESC: begin
          if (cls_i.is_delim) begin
            eof_o = 1'b1;
            st_d  = ST_IDLE;
          end else if (cls_i.is_esc_dlm) begin
            emit_o      = 1'b1;
            emit_byte_o = DELIM;
            st_d        = ST_BODY;
          end else if (cls_i.is_esc_esc) begin
            emit_o      = 1'b1;
            emit_byte_o = ESC;
            st_d        = ST_BODY;
          end else begin
            st_d = ST_BODY;
          end
        end
        default: st_d = ST_IDLE;
      endcase
      if (emit_o) begin
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_d == LIMIT) begin
          eof_o = 1'b1;
          st_d  = ST_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign st_o  = st_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/kdec_outreg.sv
module kdec_outreg
  import kdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              emit_i,
  input  logic [BYTE_W-1:0] emit_byte_i,
  input  logic              sof_i,
  input  logic              eof_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              sof_o,
  output logic              eof_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      sof_o   <= 1'b0;
      eof_o   <= 1'b0;
      byte_o  <= '0;
    end else begin
      valid_o <= emit_i;
      sof_o   <= sof_i;
      eof_o   <= eof_i;
      if (emit_i) byte_o <= emit_byte_i;
    end
  end
endmodule

// File: rtl/kiss_stream_decoder.sv
module kiss_stream_decoder
  import kdec_pkg::*;
#(
  parameter int MAX_LEN = 256,
  localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_sof,
  output logic              out_eof
);
  kdec_class_t      cls;
  logic             emit, sof, eof;
  logic [BYTE_W-1:0] emit_byte;
  kdec_state_t      st_q;
  logic [CNT_W-1:0] cnt_q;

  kdec_classify u_classify (
    .byte_i (in_byte),
    .cls_o  (cls)
  );

  kdec_ctrl #(.MAX_LEN(MAX_LEN)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .valid_i     (in_valid),
    .byte_i      (in_byte),
    .cls_i       (cls),
    .emit_o      (emit),
    .emit_byte_o (emit_byte),
    .sof_o       (sof),
    .eof_o       (eof),
    .st_o        (st_q),
    .cnt_o       (cnt_q)
  );

  kdec_outreg u_outreg (
    .clk         (clk),
    .rst         (rst),
    .emit_i      (emit),
    .emit_byte_i (emit_byte),
    .sof_i       (sof),
    .eof_i       (eof),
    .valid_o     (out_valid),
    .byte_o      (out_byte),
    .sof_o       (out_sof),
    .eof_o       (out_eof)
  );
endmodule

// File: rtl/kdec_checker.sv
module kdec_checker
  import kdec_pkg::*;
#(
  parameter int MAX_LEN = 256,
  localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [BYTE_W-1:0] in_byte,
  input kdec_state_t       st,
  input logic [CNT_W-1:0]  cnt,
  input logic              out_valid,
  input logic [BYTE_W-1:0] out_byte,
  input logic              out_sof,
  input logic              out_eof
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> !(out_valid || out_sof || out_eof));

  a_r2_sof_alone: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> !out_valid && !out_eof);

  a_r3_passthrough: assert property (@(posedge clk) disable iff (rst)
    (in_valid && st == ST_BODY && in_byte != DELIM && in_byte != ESC)
      |=> out_valid && out_byte == $past(in_byte));

  a_r5_esc_delim: assert property (@(posedge clk) disable iff (rst)
    (in_valid && st == ST_ESC && in_byte == ESC_DLM)
      |=> out_valid && out_byte == DELIM);

  a_r7_esc_error: assert property (@(posedge clk) disable iff (rst)
    (in_valid && st == ST_ESC && in_byte == DELIM)
      |=> out_eof && !out_valid);

  a_r9_idle_gap: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !(out_valid || out_sof || out_eof) && $stable(st) && $stable(cnt));

  a_r11_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(MAX_LEN));

  a_r11_sof_single: assert property (@(posedge clk) disable iff (rst)
    out_sof |=> !out_sof);
endmodule

bind kiss_stream_decoder kdec_checker #(.MAX_LEN(MAX_LEN)) u_kdec_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_byte   (in_byte),
  .st        (st_q),
  .cnt       (cnt_q),
  .out_valid (out_valid),
  .out_byte  (out_byte),
  .out_sof   (out_sof),
  .out_eof   (out_eof)
);

// File: tb/test_kiss_stream_decoder.sv
`timescale 1ns/1ps
module test_kiss_stream_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       out_valid, out_sof, out_eof;
  logic [7:0] out_byte;
  int         n_run  = 0;
  int         n_fail = 0;

  always #2 clk = ~clk;

  kiss_stream_decoder i_kiss_stream_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_byte(out_byte), .out_sof(out_sof), .out_eof(out_eof)
  );

  // {valid, byte, exp_dv, exp_byte, exp_sof, exp_eof}
  localparam int NV = 19;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 8'h41, 1'b0, 8'h00, 1'b0, 1'b0},  // R10 ignored outside frame
    {1'b1, 8'hC0, 1'b0, 8'h00, 1'b1, 1'b0},  // R2 open
    {1'b1, 8'h11, 1'b1, 8'h11, 1'b0, 1'b0},  // R3 plain byte
    {1'b0, 8'hC0, 1'b0, 8'h00, 1'b0, 1'b0},  // R9 gap with delimiter on bus
    {1'b1, 8'hDB, 1'b0, 8'h00, 1'b0, 1'b0},  // R5 arm escape
    {1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0},  // R9 gap while armed
    {1'b1, 8'hDC, 1'b1, 8'hC0, 1'b0, 1'b0},  // R5 -> 0xC0
    {1'b1, 8'hDB, 1'b0, 8'h00, 1'b0, 1'b0},  // R5
    {1'b1, 8'hDD, 1'b1, 8'hDB, 1'b0, 1'b0},  // R5 -> 0xDB
    {1'b1, 8'hDB, 1'b0, 8'h00, 1'b0, 1'b0},  // R6
    {1'b1, 8'h55, 1'b0, 8'h00, 1'b0, 1'b0},  // R6 invalid escape dropped
    {1'b1, 8'h22, 1'b1, 8'h22, 1'b0, 1'b0},  // R6 back in body
    {1'b1, 8'hC0, 1'b0, 8'h00, 1'b0, 1'b1},  // R4 close
    {1'b1, 8'hC0, 1'b0, 8'h00, 1'b1, 1'b0},  // R2 reopen
    {1'b1, 8'hDB, 1'b0, 8'h00, 1'b0, 1'b0},  // R7
    {1'b1, 8'hC0, 1'b0, 8'h00, 1'b0, 1'b1},  // R7 delimiter inside escape
    {1'b1, 8'hDD, 1'b0, 8'h00, 1'b0, 1'b0},  // R10
    {1'b1, 8'hC0, 1'b0, 8'h00, 1'b1, 1'b0},  // R2
    {1'b1, 8'hC0, 1'b0, 8'h00, 1'b0, 1'b1}   // R4 empty frame
  };

  task automatic check(string req, logic dv, logic [7:0] db, logic sf, logic ef);
    logic [10:0] act, exp;
    act = {out_valid, out_sof, out_eof, dv ? out_byte : 8'h00};
    exp = {dv, sf, ef, dv ? db : 8'h00};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got {dv,sof,eof,byte}=%b expected %b", req, act, exp);
    end
  endtask

  task automatic step(logic v, logic [7:0] b);
    in_valid = v;
    in_byte  = b;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: outputs quiet during reset
    repeat (3) @(negedge clk);
    check("R1", 1'b0, 8'h00, 1'b0, 1'b0);
    rst = 1'b0;
    step(1'b1, 8'h33);
    check("R1", 1'b0, 8'h00, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][19], VEC[i][18:11]);
      check($sformatf("vector %0d", i), VEC[i][10], VEC[i][9:2], VEC[i][1], VEC[i][0]);
    end

    // R1: reset mid-frame returns outside any frame
    step(1'b1, 8'hC0);
    check("R1", 1'b0, 8'h00, 1'b1, 1'b0);
    step(1'b1, 8'h12);
    check("R1", 1'b1, 8'h12, 1'b0, 1'b0);
    rst = 1'b1;
    step(1'b0, 8'h00);
    check("R1", 1'b0, 8'h00, 1'b0, 1'b0);
    rst = 1'b0;
    step(1'b1, 8'h34);
    check("R1", 1'b0, 8'h00, 1'b0, 1'b0);

    // R8: full-length frame, forced close at byte 256
    step(1'b1, 8'hC0);
    check("R8", 1'b0, 8'h00, 1'b1, 1'b0);
    for (int i = 0; i < 256; i++) begin
      logic [7:0] b;
      b = 8'(i % 8'hB0);
      step(1'b1, b);
      check("R8", 1'b1, b, 1'b0, i == 255);
    end
    step(1'b1, 8'h44);
    check("R8", 1'b0, 8'h00, 1'b0, 1'b0);
    step(1'b1, 8'hC0);
    check("R8", 1'b0, 8'h00, 1'b1, 1'b0);
    step(1'b1, 8'h66);
    check("R3", 1'b1, 8'h66, 1'b0, 1'b0);
    step(1'b0, 8'h00);
    check("R9", 1'b0, 8'h00, 1'b0, 1'b0);
    step(1'b1, 8'hC0);
    check("R4", 1'b0, 8'h00, 1'b0, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule